// File: doc/BRIEF.md
# Transmit FIFO with Programmable Start and Space Levels

This block buffers outgoing packet data between a host or DMA writer and a MAC transmit engine. Each entry holds 64 data bits plus a start-of-packet and an end-of-packet marker. The writer does not watch a full flag. It watches a space flag, which goes high only when enough free entries exist for the burst it plans to write. The transmit engine does not see data as soon as the FIFO is non-empty. It sees a packet's first entry only after a programmable number of valid entries has built up, or after the packet's last entry has been written. This keeps the transmitter from running dry in the middle of a frame.

Once a packet has begun, its remaining entries are offered as soon as they are present, until the end marker has been read. An optional hold mode keeps the first few entries of each packet counted as occupied after they are read. Those entries are freed only once more than a programmable number of the packet's entries have gone out, or when the packet ends. All thresholds are static configuration inputs. A threshold larger than the FIFO depth is an illegal setting. The depth must be a power of two.

Top module: `tx_thr_fifo`

## Requirements
- R1: Entries leave in the order they were written, and each keeps its 64-bit data, its start marker (`rd_sop`) and its end marker (`rd_eop`).
- R2: With `cfg_dma_en` low, `space_ok` is 1 exactly when (DEPTH minus occupied entries) is at least `cfg_wr_thresh`.
- R3: With `cfg_dma_en` high, `cfg_wr_thresh` is ignored. The free-entry threshold is 8 when `cfg_dma_burst` is 1 and 4 when it is 0.
- R4: Between packets, `rd_valid` rises only when the count of unread entries is at least `cfg_rd_thresh`, unless R5 applies.
- R5: Between packets, if an entry with the end marker is present in the FIFO, `rd_valid` is 1 whenever the FIFO is not empty, whatever the read threshold.
- R6: After a read of a non-end entry, `rd_valid` equals "FIFO not empty" until an end entry is read. After that, the read threshold governs the next packet again.
- R7: With `cfg_hold_en` high, read entries of a packet stay occupied (for R2 and R3 and for full) until a read brings the packet's read count above `cfg_release_cnt`, or until the end entry is read. At that point all of them are freed at once.
- R8: A write and a read accepted in the same cycle leave the unread and occupied counts unchanged.
- R9: A write while all DEPTH entries are occupied is dropped. `rd_ready` while `rd_valid` is 0 reads nothing.
- R10: After reset the FIFO is empty, `rd_valid` is 0, and `space_ok` is 1 for any legal write threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_thresh | input | 7 | Free-entry level for `space_ok` when not in DMA mode |
| cfg_rd_thresh | input | 7 | Unread-entry level needed to start a packet |
| cfg_dma_en | input | 1 | Use the fixed DMA free-entry level |
| cfg_dma_burst | input | 1 | DMA level select: 1 gives 8, 0 gives 4 |
| cfg_hold_en | input | 1 | Keep the start of each packet occupied after reading |
| cfg_release_cnt | input | 6 | Packet entries read before the held start is freed |
| wr_valid | input | 1 | Write request |
| wr_data | input | 64 | Write data |
| wr_sop | input | 1 | Entry is the first of a packet |
| wr_eop | input | 1 | Entry is the last of a packet |
| space_ok | output | 1 | Free entries meet the active write threshold |
| rd_ready | input | 1 | Transmit engine takes the head entry |
| rd_valid | output | 1 | Head entry may be taken |
| rd_data | output | 64 | Head entry data |
| rd_sop | output | 1 | Head entry start marker |
| rd_eop | output | 1 | Head entry end marker |

## Verification
An occupancy count that is off by even one entry moves the edge of `space_ok` in a sweep of fill level against the write threshold, and it does so in the same cycle as the faulty update. An error in the unread count or in the end-marker count moves the level at which `rd_valid` rises between packets. A packet-state flag stuck in either value shows up within one read, as a stall in the middle of a packet or as a start below threshold. A free pointer that is released early or late moves the `space_ok` edge during a held packet by the number of entries held.

// File: rtl/tx_thr_pkg.sv
package tx_thr_pkg;

    localparam int unsigned DMA_LVL_SINGLE = 4;
    localparam int unsigned DMA_LVL_BURST  = 8;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_PKT  = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/tx_thr_store.sv
module tx_thr_store #(
    parameter int unsigned EW    = 66,
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [EW-1:0] wr_entry,
    input  logic [AW-1:0] rd_addr,
    output logic [EW-1:0] rd_entry
);

    logic [EW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_entry;
        end
    end

    assign rd_entry = mem_q[rd_addr];

endmodule

// File: rtl/tx_thr_space.sv
module tx_thr_space #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned TW    = 7,
    localparam int unsigned PW   = $clog2(DEPTH) + 1,
    localparam int unsigned CW   = (PW > TW) ? PW : TW
) (
    input  logic [PW-1:0] used_cnt,
    input  logic [TW-1:0] cfg_wr_thresh,
    input  logic          cfg_dma_en,
    input  logic          cfg_dma_burst,
    output logic          space_ok
);
    import tx_thr_pkg::*;

    logic [PW-1:0] free_cnt;
    logic [TW-1:0] lvl;

    always_comb begin
        free_cnt = PW'(DEPTH) - used_cnt;
        if (cfg_dma_en) begin
            lvl = cfg_dma_burst ? TW'(DMA_LVL_BURST) : TW'(DMA_LVL_SINGLE);
        end else begin
            lvl = cfg_wr_thresh;
        end
        space_ok = CW'(free_cnt) >= CW'(lvl);
    end

endmodule

// File: rtl/tx_thr_gate.sv
module tx_thr_gate #(
    parameter int unsigned PW  = 8,
    parameter int unsigned TW  = 7,
    parameter int unsigned RLW = 6,
    localparam int unsigned CW = (PW > TW) ? PW : TW,
    localparam int unsigned BW = RLW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PW-1:0]  vld_cnt,
    input  logic [PW-1:0]  eop_cnt,
    input  logic           head_eop,
    input  logic           rd_ready,
    input  logic [TW-1:0]  cfg_rd_thresh,
    input  logic           cfg_hold_en,
    input  logic [RLW-1:0] cfg_release_cnt,
    output logic           rd_valid,
    output logic           rd_fire,
    output logic           release_now,
    output logic           in_pkt
);
    import tx_thr_pkg::*;

    typedef struct packed {
        rd_mode_e      mode;
        logic [BW-1:0] beats;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic [BW-1:0] beats_next;
    logic          start_ok;

    always_comb begin
        st_d       = st_q;
        in_pkt     = (st_q.mode == RD_PKT);
        start_ok   = (CW'(vld_cnt) >= CW'(cfg_rd_thresh)) || (eop_cnt != '0);
        rd_valid   = (vld_cnt != '0) && (in_pkt || start_ok);
        rd_fire    = rd_valid && rd_ready;
        beats_next = in_pkt ? st_q.beats : '0;
        if (beats_next != '1) begin
            beats_next = beats_next + BW'(1);
        end
        release_now = rd_fire &&
                      (!cfg_hold_en || head_eop || (beats_next > BW'(cfg_release_cnt)));
        if (rd_fire) begin
            if (head_eop) begin
                st_d.mode  = RD_IDLE;
                st_d.beats = '0;
            end else begin
                st_d.mode  = RD_PKT;
                st_d.beats = beats_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= RD_IDLE;
            st_q.beats <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tx_thr_fifo.sv
module tx_thr_fifo #(
    parameter int unsigned DW    = 64,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned TW    = 7,
    parameter int unsigned RLW   = 6,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1,
    localparam int unsigned EW   = DW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  cfg_wr_thresh,
    input  logic [TW-1:0]  cfg_rd_thresh,
    input  logic           cfg_dma_en,
    input  logic           cfg_dma_burst,
    input  logic           cfg_hold_en,
    input  logic [RLW-1:0] cfg_release_cnt,
    input  logic           wr_valid,
    input  logic [DW-1:0]  wr_data,
    input  logic           wr_sop,
    input  logic           wr_eop,
    output logic           space_ok,
    input  logic           rd_ready,
    output logic           rd_valid,
    output logic [DW-1:0]  rd_data,
    output logic           rd_sop,
    output logic           rd_eop
);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [PW-1:0] fptr;
        logic [PW-1:0] eops;
    } ptr_st_t;

    ptr_st_t       st_d, st_q;
    logic [PW-1:0] vld_cnt;
    logic [PW-1:0] used_cnt;
    logic          wr_acc;
    logic          rd_fire;
    logic          release_now;
    logic          in_pkt;
    logic [EW-1:0] head;

    tx_thr_store #(.EW(EW), .DEPTH(DEPTH)) store_i (
        .clk      (clk),
        .wr_en    (wr_acc),
        .wr_addr  (st_q.wptr[AW-1:0]),
        .wr_entry ({wr_sop, wr_eop, wr_data}),
        .rd_addr  (st_q.rptr[AW-1:0]),
        .rd_entry (head)
    );

    tx_thr_space #(.DEPTH(DEPTH), .TW(TW)) space_i (
        .used_cnt      (used_cnt),
        .cfg_wr_thresh (cfg_wr_thresh),
        .cfg_dma_en    (cfg_dma_en),
        .cfg_dma_burst (cfg_dma_burst),
        .space_ok      (space_ok)
    );

    tx_thr_gate #(.PW(PW), .TW(TW), .RLW(RLW)) gate_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .vld_cnt         (vld_cnt),
        .eop_cnt         (st_q.eops),
        .head_eop        (rd_eop),
        .rd_ready        (rd_ready),
        .cfg_rd_thresh   (cfg_rd_thresh),
        .cfg_hold_en     (cfg_hold_en),
        .cfg_release_cnt (cfg_release_cnt),
        .rd_valid        (rd_valid),
        .rd_fire         (rd_fire),
        .release_now     (release_now),
        .in_pkt          (in_pkt)
    );

    assign rd_sop  = head[EW-1];
    assign rd_eop  = head[EW-2];
    assign rd_data = head[DW-1:0];

    always_comb begin
        st_d     = st_q;
        vld_cnt  = st_q.wptr - st_q.rptr;
        used_cnt = st_q.wptr - st_q.fptr;
        wr_acc   = wr_valid && (used_cnt != PW'(DEPTH));
        if (wr_acc) begin
            st_d.wptr = st_q.wptr + PW'(1);
        end
        if (rd_fire) begin
            st_d.rptr = st_q.rptr + PW'(1);
        end
        if (release_now) begin
            st_d.fptr = st_d.rptr;
        end
        st_d.eops = st_q.eops + PW'(wr_acc && wr_eop) - PW'(rd_fire && rd_eop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tx_thr_fifo_chk.sv
module tx_thr_fifo_chk #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned PW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] used_cnt,
    input logic [PW-1:0] vld_cnt,
    input logic          wr_valid,
    input logic          wr_acc,
    input logic          rd_fire,
    input logic          rd_valid,
    input logic          in_pkt
);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt <= PW'(DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (used_cnt == PW'(DEPTH) && wr_valid && !rd_fire) |=> used_cnt == $past(used_cnt));

    // R9
    empty_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_cnt == '0) |-> !rd_valid);

    // R8
    rw_same_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && rd_fire) |=> vld_cnt == $past(vld_cnt));

    // R6
    pkt_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pkt && vld_cnt != '0) |-> rd_valid);

    // R7
    held_ge_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt >= vld_cnt);

endmodule

bind tx_thr_fifo tx_thr_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .used_cnt (used_cnt),
    .vld_cnt  (vld_cnt),
    .wr_valid (wr_valid),
    .wr_acc   (wr_acc),
    .rd_fire  (rd_fire),
    .rd_valid (rd_valid),
    .in_pkt   (in_pkt)
);

// File: tb/tx_thr_fifo_tb_top.sv
`timescale 1ns/1ps
module tx_thr_fifo_tb_top;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_wr_thresh = '0;
    logic [6:0]  cfg_rd_thresh = 7'd1;
    logic        cfg_dma_en = 1'b0;
    logic        cfg_dma_burst = 1'b0;
    logic        cfg_hold_en = 1'b0;
    logic [5:0]  cfg_release_cnt = '0;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_sop = 1'b0;
    logic        wr_eop = 1'b0;
    logic        space_ok;
    logic        rd_ready = 1'b0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        rd_sop;
    logic        rd_eop;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tx_thr_fifo #(.DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_thresh(cfg_wr_thresh), .cfg_rd_thresh(cfg_rd_thresh),
        .cfg_dma_en(cfg_dma_en), .cfg_dma_burst(cfg_dma_burst),
        .cfg_hold_en(cfg_hold_en), .cfg_release_cnt(cfg_release_cnt),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .space_ok(space_ok), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [63:0] d, input logic s, input logic e);
        wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
        @(negedge clk);
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic pop();
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic drain();
        rd_ready = 1'b1;
        while (rd_valid) @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic flush();
        cfg_rd_thresh = 7'd1;
        #1;
        drain();
        push(64'h0, 1'b1, 1'b1);
        drain();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        cfg_wr_thresh = 7'd16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rd_valid", rd_valid, 0);
        chk("R10 space at depth", space_ok, 1);
        cfg_wr_thresh = 7'd0; #1;
        chk("R10 space at zero", space_ok, 1);

        // R2 sweep of write threshold against fill level
        for (int w = 0; w <= D; w++) begin
            cfg_wr_thresh = 7'(w);
            for (int k = 0; k <= D; k++) begin
                if (k > 0) push(64'(k), 1'b0, 1'b0);
                #1;
                chk("R2 space", space_ok, 64'((D - k) >= w));
            end
            flush();
        end

        // R3 DMA levels, cfg_wr_thresh ignored
        cfg_dma_en = 1'b1;
        cfg_wr_thresh = 7'd15;
        for (int b = 0; b < 2; b++) begin
            cfg_dma_burst = b[0];
            for (int k = 0; k <= D; k++) begin
                if (k > 0) push(64'(k), 1'b0, 1'b0);
                #1;
                chk("R3 dma space", space_ok, 64'((D - k) >= (b != 0 ? 8 : 4)));
            end
            flush();
        end
        cfg_dma_en = 1'b0;

        // R4 sweep of read threshold against unread count
        for (int r = 1; r <= D; r++) begin
            cfg_rd_thresh = 7'(r);
            for (int n = 1; n <= D; n++) begin
                push(64'(n), 1'b0, 1'b0);
                chk("R4 start gate", rd_valid, 64'(n >= r));
            end
            flush();
        end

        // R5 end marker releases a short packet
        cfg_rd_thresh = 7'd10;
        push(64'h51, 1'b1, 1'b0);
        push(64'h52, 1'b0, 1'b0);
        chk("R5 before end", rd_valid, 0);
        push(64'h53, 1'b0, 1'b1);
        chk("R5 after end", rd_valid, 1);
        flush();

        // R6 continuation inside a packet, threshold again for next
        cfg_rd_thresh = 7'd4;
        for (int i = 0; i < 4; i++) push(64'(100 + i), i == 0, 1'b0);
        chk("R6 start", rd_valid, 1);
        pop(); pop();
        chk("R6 continue below thr", rd_valid, 1);
        chk("R6 data", rd_data, 64'd102);
        push(64'd104, 1'b0, 1'b1);
        pop(); pop(); pop();
        chk("R6 packet done", rd_valid, 0);
        push(64'd110, 1'b1, 1'b0);
        push(64'd111, 1'b0, 1'b0);
        chk("R6 next pkt gated", rd_valid, 0);
        push(64'd112, 1'b0, 1'b0);
        push(64'd113, 1'b0, 1'b0);
        chk("R6 next pkt starts", rd_valid, 1);
        flush();

        // R1 order and markers, R9 write while full dropped
        cfg_wr_thresh = 7'd1;
        cfg_rd_thresh = 7'd16;
        for (int i = 0; i < D; i++) push(64'hA5A5_0000 + 64'(i), i == 0, i == D - 1);
        chk("R9 full no space", space_ok, 0);
        push(64'hDEAD, 1'b1, 1'b1);
        cfg_rd_thresh = 7'd1; #1;
        for (int i = 0; i < D; i++) begin
            chk("R1 valid", rd_valid, 1);
            chk("R1 data", rd_data, 64'hA5A5_0000 + 64'(i));
            chk("R1 sop", rd_sop, 64'(i == 0));
            chk("R1 eop", rd_eop, 64'(i == D - 1));
            pop();
        end
        chk("R9 extra write dropped", rd_valid, 0);
        // R9 read while empty ignored
        rd_ready = 1'b1;
        repeat (2) @(negedge clk);
        rd_ready = 1'b0;
        push(64'hBEEF, 1'b1, 1'b1);
        chk("R9 empty read ignored", rd_data, 64'hBEEF);
        chk("R9 empty read valid", rd_valid, 1);
        pop();

        // R8 simultaneous read and write
        cfg_rd_thresh = 7'd1;
        cfg_wr_thresh = 7'd11;
        for (int i = 0; i < 5; i++) push(64'(200 + i), i == 0, 1'b0);
        chk("R8 pre space", space_ok, 1);
        wr_valid = 1'b1; wr_data = 64'd205; rd_ready = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; rd_ready = 1'b0;
        #1;
        chk("R8 space same", space_ok, 1);
        cfg_wr_thresh = 7'd12; #1;
        chk("R8 count same", space_ok, 0);
        chk("R8 head", rd_data, 64'd201);
        flush();

        // R7 hold mode, release by count
        cfg_hold_en = 1'b1;
        cfg_release_cnt = 6'd3;
        cfg_wr_thresh = 7'd11;
        cfg_rd_thresh = 7'd1;
        for (int i = 0; i < 6; i++) push(64'(300 + i), i == 0, i == 5);
        chk("R7 filled", space_ok, 0);
        for (int i = 1; i <= 6; i++) begin
            pop();
            #1;
            chk("R7 held by count", space_ok, 64'(i > 3));
        end
        // R7 hold mode, release by end marker
        cfg_release_cnt = 6'd10;
        cfg_wr_thresh = 7'd16;
        for (int i = 0; i < 3; i++) push(64'(400 + i), i == 0, i == 2);
        pop(); pop();
        #1;
        chk("R7 held to end", space_ok, 0);
        pop();
        #1;
        chk("R7 freed at end", space_ok, 1);
        cfg_hold_en = 1'b0;

        finish_run();
    end

endmodule